// File: doc/BRIEF.md
# Interrupt Controller Global Register File

This block holds the controller-wide registers of a multiprocessor interrupt controller. A host reaches it over a simple 32-bit register bus that carries a one-cycle write strobe and a one-cycle read strobe. Read data is registered and is valid in the cycle after the read strobe. The block decodes word offsets inside a 256-byte window.

It stores a global configuration word, a spurious vector and a timer frequency word. It returns two fixed identification words. It keeps a per-processor reset mask that drives the processor reset lines, changing a line only on a transition of its mask bit. Setting the top bit of the configuration word starts a controller reset: the register file returns to its reset values and a one-cycle pulse tells the neighbouring sections to do the same.

Accesses to the vector/priority words of the four inter-processor interrupt sources are not stored here. They are forwarded to an external source-register port, together with the source index.

Top module: `intc_global_regs`

## Requirements
- R1: An access whose address has any of bits [3:0] set is misaligned. A misaligned write changes nothing and raises no strobe. A misaligned read returns 0xFFFFFFFF.
- R2: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.
- R3: A write to offset 0x20 stores the written word with bit 31 forced to 0. The stored word drives `cfg_o` and is read back from 0x20.
- R4: A write to 0x20 with bit 31 set is a controller reset. After that edge the spurious vector is SPUR_RST, the timer frequency is TFRQ_RST, and the processor reset mask and lines are 0. `ctl_reset_pulse_o` is high for exactly the next cycle.
- R5: A write to offset 0x90 acts on bit i (i < NUM_PROC) of the data. A 0-to-1 change against the stored mask raises `proc_reset_o[i]`, a 1-to-0 change lowers it, and an unchanged bit leaves the line alone. Data bits at or above NUM_PROC have no effect.
- R6: Offset 0x90 always reads as 0.
- R7: A write to offset 0xE0 keeps only data bits [7:0]. The value drives `spur_vec_o` and reads back zero-extended.
- R8: Offset 0xF0 is a full 32-bit read/write timer frequency word that drives `timer_freq_o`.
- R9: Offset 0x00 reads FEATURE_WORD and offset 0x80 reads VENDOR_WORD. Writes to either have no effect.
- R10: Offsets 0xA0, 0xB0, 0xC0 and 0xD0 map to inter-processor source index 0 to 3, computed as (offset - 0xA0) >> 4. A write there raises `ipi_wr_o` for that cycle with `ipi_sel_o` set to the index and `ipi_wdata_o` set to the data. A read raises `ipi_rd_o` and returns `ipi_rdata_i`.
- R11: An aligned offset that is not listed above reads 0xFFFFFFFF. A write to it has no effect.
- R12: After `rst_n` the configuration word is 0, the spurious vector is SPUR_RST, the timer frequency is TFRQ_RST, the processor reset lines are 0, `bus_rdata` is 0 and the reset pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 8 | Byte offset in the global window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| proc_reset_o | output | NUM_PROC | Per-processor reset lines |
| ctl_reset_pulse_o | output | 1 | One-cycle controller reset pulse to other sections |
| cfg_o | output | 32 | Stored configuration word |
| spur_vec_o | output | 8 | Spurious vector |
| timer_freq_o | output | 32 | Timer frequency word |
| ipi_sel_o | output | 2 | Inter-processor source index |
| ipi_wr_o | output | 1 | Inter-processor register write strobe |
| ipi_rd_o | output | 1 | Inter-processor register read strobe |
| ipi_wdata_o | output | 32 | Inter-processor register write data |
| ipi_rdata_i | input | 32 | Inter-processor register read data, combinational from `ipi_sel_o` |

## Verification
The bench builds the block with NUM_PROC = 3, so data bits 3 and above of a processor-reset write lie outside the mask and their lack of effect can be seen on the lines. SPUR_RST = 0xA5, TFRQ_RST = 0x0BEBC200 and two distinct identification words are chosen so that every reset value differs from zero and from all-ones. That way a controller reset can be told apart both from a cleared register and from an unmapped read. The external inter-processor port is modelled as data that encodes the source index, so each of the four indices can be seen in the read data as well as in the write strobe.

// File: rtl/intc_gr_pkg.sv
package intc_gr_pkg;

  localparam int WIN_AW     = 8;
  localparam int DW         = 32;
  localparam int SPUR_W     = 8;
  localparam int IPI_COUNT  = 4;
  localparam int IPI_IW     = $clog2(IPI_COUNT);
  localparam int IPI_STRIDE = 16;
  localparam int CMD_BIT    = 31;

  localparam logic [WIN_AW-1:0] OFS_FEAT   = 8'h00;
  localparam logic [WIN_AW-1:0] OFS_CFG    = 8'h20;
  localparam logic [WIN_AW-1:0] OFS_VEND   = 8'h80;
  localparam logic [WIN_AW-1:0] OFS_PRST   = 8'h90;
  localparam logic [WIN_AW-1:0] OFS_IPI_LO = 8'hA0;
  localparam logic [WIN_AW-1:0] OFS_SPUR   = 8'hE0;
  localparam logic [WIN_AW-1:0] OFS_TFRQ   = 8'hF0;

  localparam logic [DW-1:0] ALL_ONES = '1;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_MISAL,
    RG_FEAT,
    RG_CFG,
    RG_VEND,
    RG_PRST,
    RG_IPI,
    RG_SPUR,
    RG_TFRQ
  } reg_sel_e;

  function automatic logic word_aligned(input logic [WIN_AW-1:0] a);
    return (a[3:0] == 4'h0);
  endfunction

  function automatic logic [IPI_IW-1:0] ipi_index(input logic [WIN_AW-1:0] a);
    logic [WIN_AW-1:0] d;
    d = a - OFS_IPI_LO;
    return d[IPI_IW+3:4];
  endfunction

  function automatic logic [DW-1:0] strip_cmd(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = v;
    r[CMD_BIT] = 1'b0;
    return r;
  endfunction

  function automatic logic [DW-1:0] rising_bits(input logic [DW-1:0] old_v,
                                                input logic [DW-1:0] new_v);
    return new_v & ~old_v;
  endfunction

  function automatic logic [DW-1:0] falling_bits(input logic [DW-1:0] old_v,
                                                 input logic [DW-1:0] new_v);
    return old_v & ~new_v;
  endfunction

endpackage

// File: rtl/intc_gr_decode.sv
module intc_gr_decode
  import intc_gr_pkg::*;
#(
  parameter int NUM_IPI = IPI_COUNT
) (
  input  logic [WIN_AW-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [IPI_IW-1:0] ipi_idx_o
);

  logic [NUM_IPI-1:0] ipi_hit;

  for (genvar g = 0; g < NUM_IPI; g++) begin : g_ipi_hit
    assign ipi_hit[g] = (addr_i == (OFS_IPI_LO + WIN_AW'(g * IPI_STRIDE)));
  end

  always_comb begin
    if (!word_aligned(addr_i)) begin
      sel_o = RG_MISAL;
    end else if (|ipi_hit) begin
      sel_o = RG_IPI;
    end else begin
      case (addr_i)
        OFS_FEAT: sel_o = RG_FEAT;
        OFS_CFG:  sel_o = RG_CFG;
        OFS_VEND: sel_o = RG_VEND;
        OFS_PRST: sel_o = RG_PRST;
        OFS_SPUR: sel_o = RG_SPUR;
        OFS_TFRQ: sel_o = RG_TFRQ;
        default:  sel_o = RG_NONE;
      endcase
    end
  end

  assign ipi_idx_o = ipi_index(addr_i);

endmodule

// File: rtl/intc_gr_procrst.sv
module intc_gr_procrst
  import intc_gr_pkg::*;
#(
  parameter int NUM_PROC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                wr_i,
  input  logic [NUM_PROC-1:0] mask_i,
  output logic [NUM_PROC-1:0] line_o,
  output logic [NUM_PROC-1:0] rise_o,
  output logic [NUM_PROC-1:0] fall_o
);

  logic [NUM_PROC-1:0] mask_q;
  logic [NUM_PROC-1:0] line_q;
  logic [DW-1:0]       old_w;
  logic [DW-1:0]       new_w;
  logic [DW-1:0]       rise_w;
  logic [DW-1:0]       fall_w;

  assign old_w  = DW'(mask_q);
  assign new_w  = DW'(mask_i);
  assign rise_w = rising_bits(old_w, new_w);
  assign fall_w = falling_bits(old_w, new_w);

  assign rise_o = wr_i ? rise_w[NUM_PROC-1:0] : '0;
  assign fall_o = wr_i ? fall_w[NUM_PROC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (clr_i) begin
      mask_q <= '0;
    end else if (wr_i) begin
      mask_q <= mask_i;
    end
  end

  for (genvar g = 0; g < NUM_PROC; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q[g] <= 1'b0;
      end else if (clr_i) begin
        line_q[g] <= 1'b0;
      end else if (rise_o[g]) begin
        line_q[g] <= 1'b1;
      end else if (fall_o[g]) begin
        line_q[g] <= 1'b0;
      end
    end
  end

  assign line_o = line_q;

endmodule

// File: rtl/intc_gr_store.sv
module intc_gr_store
  import intc_gr_pkg::*;
#(
  parameter logic [SPUR_W-1:0] SPUR_RST = 8'hFF,
  parameter logic [DW-1:0]     TFRQ_RST = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              cfg_wr_i,
  input  logic              spur_wr_i,
  input  logic              tfrq_wr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     cfg_o,
  output logic [SPUR_W-1:0] spur_o,
  output logic [DW-1:0]     tfrq_o,
  output logic              pulse_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o <= '0;
    end else if (cfg_wr_i) begin
      cfg_o <= strip_cmd(wdata_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spur_o <= SPUR_RST;
    end else if (clr_i) begin
      spur_o <= SPUR_RST;
    end else if (spur_wr_i) begin
      spur_o <= wdata_i[SPUR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tfrq_o <= TFRQ_RST;
    end else if (clr_i) begin
      tfrq_o <= TFRQ_RST;
    end else if (tfrq_wr_i) begin
      tfrq_o <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= clr_i;
    end
  end

endmodule

// File: rtl/intc_gr_rdmux.sv
module intc_gr_rdmux
  import intc_gr_pkg::*;
#(
  parameter logic [DW-1:0] FEATURE_WORD = 32'h0003_0F02,
  parameter logic [DW-1:0] VENDOR_WORD  = 32'h0000_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  reg_sel_e          sel_i,
  input  logic [DW-1:0]     cfg_i,
  input  logic [SPUR_W-1:0] spur_i,
  input  logic [DW-1:0]     tfrq_i,
  input  logic [DW-1:0]     ipi_i,
  output logic [DW-1:0]     rdata_o
);

  logic [DW-1:0] next_word;

  always_comb begin
    case (sel_i)
      RG_FEAT: next_word = FEATURE_WORD;
      RG_CFG:  next_word = cfg_i;
      RG_VEND: next_word = VENDOR_WORD;
      RG_PRST: next_word = '0;
      RG_IPI:  next_word = ipi_i;
      RG_SPUR: next_word = DW'(spur_i);
      RG_TFRQ: next_word = tfrq_i;
      default: next_word = ALL_ONES;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      rdata_o <= next_word;
    end
  end

endmodule

// File: rtl/intc_global_regs.sv
module intc_global_regs
  import intc_gr_pkg::*;
#(
  parameter int                NUM_PROC     = 4,
  parameter logic [DW-1:0]     FEATURE_WORD = 32'h0003_0F02,
  parameter logic [DW-1:0]     VENDOR_WORD  = 32'h0000_0002,
  parameter logic [SPUR_W-1:0] SPUR_RST     = 8'hFF,
  parameter logic [DW-1:0]     TFRQ_RST     = 32'h0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_PROC-1:0] proc_reset_o,
  output logic                ctl_reset_pulse_o,
  output logic [31:0]         cfg_o,
  output logic [7:0]          spur_vec_o,
  output logic [31:0]         timer_freq_o,
  output logic [1:0]          ipi_sel_o,
  output logic                ipi_wr_o,
  output logic                ipi_rd_o,
  output logic [31:0]         ipi_wdata_o,
  input  logic [31:0]         ipi_rdata_i
);

  reg_sel_e            sel;
  logic [IPI_IW-1:0]   ipi_idx;
  logic                wr_cfg;
  logic                wr_prst;
  logic                wr_spur;
  logic                wr_tfrq;
  logic                soft_cmd;
  logic [NUM_PROC-1:0] prst_rise;
  logic [NUM_PROC-1:0] prst_fall;

  intc_gr_decode #(.NUM_IPI(IPI_COUNT)) u_dec (
    .addr_i    (bus_addr),
    .sel_o     (sel),
    .ipi_idx_o (ipi_idx)
  );

  assign wr_cfg   = bus_wr && (sel == RG_CFG);
  assign wr_prst  = bus_wr && (sel == RG_PRST);
  assign wr_spur  = bus_wr && (sel == RG_SPUR);
  assign wr_tfrq  = bus_wr && (sel == RG_TFRQ);
  assign soft_cmd = wr_cfg && bus_wdata[CMD_BIT];

  intc_gr_store #(.SPUR_RST(SPUR_RST), .TFRQ_RST(TFRQ_RST)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (soft_cmd),
    .cfg_wr_i  (wr_cfg),
    .spur_wr_i (wr_spur),
    .tfrq_wr_i (wr_tfrq),
    .wdata_i   (bus_wdata),
    .cfg_o     (cfg_o),
    .spur_o    (spur_vec_o),
    .tfrq_o    (timer_freq_o),
    .pulse_o   (ctl_reset_pulse_o)
  );

  intc_gr_procrst #(.NUM_PROC(NUM_PROC)) u_prst (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (soft_cmd),
    .wr_i   (wr_prst),
    .mask_i (bus_wdata[NUM_PROC-1:0]),
    .line_o (proc_reset_o),
    .rise_o (prst_rise),
    .fall_o (prst_fall)
  );

  assign ipi_sel_o   = ipi_idx;
  assign ipi_wr_o    = bus_wr && (sel == RG_IPI);
  assign ipi_rd_o    = bus_rd && (sel == RG_IPI);
  assign ipi_wdata_o = bus_wdata;

  intc_gr_rdmux #(.FEATURE_WORD(FEATURE_WORD), .VENDOR_WORD(VENDOR_WORD)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_i    (bus_rd),
    .sel_i   (sel),
    .cfg_i   (cfg_o),
    .spur_i  (spur_vec_o),
    .tfrq_i  (timer_freq_o),
    .ipi_i   (ipi_rdata_i),
    .rdata_o (bus_rdata)
  );

endmodule

// File: rtl/intc_gr_checker.sv
module intc_gr_checker
  import intc_gr_pkg::*;
#(
  parameter int                NUM_PROC = 4,
  parameter logic [SPUR_W-1:0] SPUR_RST = 8'hFF,
  parameter logic [DW-1:0]     TFRQ_RST = 32'h0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [7:0]          bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PROC-1:0] proc_reset_o,
  input logic                ctl_reset_pulse_o,
  input logic [31:0]         cfg_o,
  input logic [7:0]          spur_vec_o,
  input logic [31:0]         timer_freq_o,
  input logic [1:0]          ipi_sel_o,
  input logic                ipi_wr_o,
  input logic                soft_cmd,
  input logic [NUM_PROC-1:0] prst_rise
);

  logic misal;
  logic ipi_addr;
  assign misal    = (bus_addr[3:0] != 4'h0);
  assign ipi_addr = !misal && (bus_addr >= 8'hA0) && (bus_addr <= 8'hD0);

  AST_MISAL_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && misal) |=> ($stable(cfg_o) && $stable(spur_vec_o) && $stable(timer_freq_o)
                           && $stable(proc_reset_o) && !ctl_reset_pulse_o)); // R1
  AST_MISAL_RD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && misal) |=> (bus_rdata == 32'hFFFF_FFFF)); // R1
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R2
  AST_CFG_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h20) |=> (cfg_o == {1'b0, $past(bus_wdata[30:0])})); // R3
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_cmd |=> (ctl_reset_pulse_o && spur_vec_o == SPUR_RST
                  && timer_freq_o == TFRQ_RST && proc_reset_o == '0)); // R4
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset_pulse_o |=> !ctl_reset_pulse_o); // R4
  AST_PRST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h90) |=> (proc_reset_o == $past(bus_wdata[NUM_PROC-1:0]))); // R5
  AST_RISE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (prst_rise != '0) |=> ((proc_reset_o & $past(prst_rise)) == $past(prst_rise))); // R5
  AST_PRST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 8'h90) |=> (bus_rdata == 32'h0)); // R6
  AST_SPUR_LOW8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'hE0) |=> (spur_vec_o == $past(bus_wdata[7:0]))); // R7
  AST_IPI_WR_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && ipi_addr) |-> (ipi_wr_o && ipi_sel_o == 2'((bus_addr - 8'hA0) >> 4))); // R10
  AST_IPI_WR_ONLY_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_wr_o |-> (bus_wr && ipi_addr)); // R10
  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 8'h10) |=> (bus_rdata == 32'hFFFF_FFFF)); // R11

endmodule

bind intc_global_regs intc_gr_checker #(
  .NUM_PROC (NUM_PROC),
  .SPUR_RST (SPUR_RST),
  .TFRQ_RST (TFRQ_RST)
) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .bus_wr            (bus_wr),
  .bus_rd            (bus_rd),
  .bus_addr          (bus_addr),
  .bus_wdata         (bus_wdata),
  .bus_rdata         (bus_rdata),
  .proc_reset_o      (proc_reset_o),
  .ctl_reset_pulse_o (ctl_reset_pulse_o),
  .cfg_o             (cfg_o),
  .spur_vec_o        (spur_vec_o),
  .timer_freq_o      (timer_freq_o),
  .ipi_sel_o         (ipi_sel_o),
  .ipi_wr_o          (ipi_wr_o),
  .soft_cmd          (soft_cmd),
  .prst_rise         (prst_rise)
);

// File: tb/sim_intc_global_regs.sv
`timescale 1ns/1ps
module sim_intc_global_regs;

  localparam int          NP   = 3;
  localparam logic [31:0] FEAT = 32'h0002_1F03;
  localparam logic [31:0] VEND = 32'h0000_00C7;
  localparam logic [7:0]  SPR  = 8'hA5;
  localparam logic [31:0] TFR  = 32'h0BEB_C200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] proc_reset;
  logic          pulse;
  logic [31:0]   cfg;
  logic [7:0]    spur;
  logic [31:0]   tfrq;
  logic [1:0]    ipi_sel;
  logic          ipi_wr;
  logic          ipi_rd;
  logic [31:0]   ipi_wdata;
  logic [31:0]   ipi_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  int ipi_wr_cnt = 0;
  int ipi_rd_cnt = 0;
  logic [1:0]  last_ipi_sel = '0;
  logic [31:0] last_ipi_data = '0;
  bit done = 0;

  always #5 clk = ~clk;

  assign ipi_rdata = 32'hC0DE_0000 | 32'(ipi_sel);

  always @(posedge clk) begin
    if (ipi_wr) begin
      ipi_wr_cnt++;
      last_ipi_sel  <= ipi_sel;
      last_ipi_data <= ipi_wdata;
    end
    if (ipi_rd) ipi_rd_cnt++;
  end

  intc_global_regs #(
    .NUM_PROC(NP), .FEATURE_WORD(FEAT), .VENDOR_WORD(VEND),
    .SPUR_RST(SPR), .TFRQ_RST(TFR)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .proc_reset_o(proc_reset), .ctl_reset_pulse_o(pulse), .cfg_o(cfg),
    .spur_vec_o(spur), .timer_freq_o(tfrq), .ipi_sel_o(ipi_sel),
    .ipi_wr_o(ipi_wr), .ipi_rd_o(ipi_rd), .ipi_wdata_o(ipi_wdata),
    .ipi_rdata_i(ipi_rdata)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    chk("R12 cfg", cfg, 32'h0);
    chk("R12 spur", 32'(spur), 32'(SPR));
    chk("R12 tfrq", tfrq, TFR);
    chk("R12 lines", 32'(proc_reset), 32'h0);
    chk("R12 pulse", 32'(pulse), 32'h0);
    chk("R12 rdata", bus_rdata, 32'h0);
    rd(8'hE0, v); chk("R12 spur read", v, 32'(SPR));
  endtask

  task automatic t_ident();
    logic [31:0] v;
    rd(8'h00, v); chk("R9 feature", v, FEAT);
    rd(8'h80, v); chk("R9 vendor", v, VEND);
    wr(8'h00, 32'h1111_1111);
    wr(8'h80, 32'h2222_2222);
    rd(8'h00, v); chk("R9 feature after write", v, FEAT);
    rd(8'h80, v); chk("R9 vendor after write", v, VEND);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    wr(8'h20, 32'h1234_5678);
    chk("R3 cfg out", cfg, 32'h1234_5678);
    rd(8'h20, v); chk("R3 cfg read", v, 32'h1234_5678);
    wr(8'h20, 32'h7FFF_FFFF);
    rd(8'h20, v); chk("R3 cfg all low bits", v, 32'h7FFF_FFFF);
    chk("R3 no pulse", 32'(pulse), 32'h0);
  endtask

  task automatic t_spur_tfrq();
    logic [31:0] v;
    wr(8'hE0, 32'hDEAD_BE3C);
    chk("R7 spur out", 32'(spur), 32'h3C);
    rd(8'hE0, v); chk("R7 spur read", v, 32'h0000_003C);
    wr(8'hF0, 32'h89AB_CDEF);
    chk("R8 tfrq out", tfrq, 32'h89AB_CDEF);
    rd(8'hF0, v); chk("R8 tfrq read", v, 32'h89AB_CDEF);
  endtask

  task automatic t_proc_reset();
    logic [31:0] v;
    wr(8'h90, 32'h0000_0005);
    chk("R5 rise 101", 32'(proc_reset), 32'h5);
    rd(8'h90, v); chk("R6 reads zero", v, 32'h0);
    wr(8'h90, 32'h0000_0006);
    chk("R5 rise1 fall0 keep2", 32'(proc_reset), 32'h6);
    wr(8'h90, 32'h0000_0006);
    chk("R5 unchanged", 32'(proc_reset), 32'h6);
    wr(8'h90, 32'hFFFF_FFF8);
    chk("R5 upper bits ignored", 32'(proc_reset), 32'h0);
    rd(8'h90, v); chk("R6 reads zero again", v, 32'h0);
  endtask

  task automatic t_misaligned();
    logic [31:0] v;
    logic [31:0] c0, t0;
    logic [7:0]  s0;
    int w0;
    c0 = cfg; s0 = spur; t0 = tfrq; w0 = ipi_wr_cnt;
    wr(8'h24, 32'h8000_0001);
    wr(8'hE8, 32'h0000_0011);
    wr(8'hF4, 32'h0000_0022);
    wr(8'hA4, 32'h0000_0033);
    chk("R1 cfg kept", cfg, c0);
    chk("R1 spur kept", 32'(spur), 32'(s0));
    chk("R1 tfrq kept", tfrq, t0);
    chk("R1 no pulse", 32'(pulse), 32'h0);
    chk("R1 no ipi strobe", 32'(ipi_wr_cnt), 32'(w0));
    rd(8'h22, v); chk("R1 misaligned read", v, 32'hFFFF_FFFF);
    rd(8'h0F, v); chk("R1 misaligned read 0F", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    logic [31:0] c0;
    c0 = cfg;
    rd(8'h10, v); chk("R11 read 10", v, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R11 read 40", v, 32'hFFFF_FFFF);
    rd(8'h70, v); chk("R11 read 70", v, 32'hFFFF_FFFF);
    wr(8'h30, 32'h8000_0000);
    chk("R11 write no pulse", 32'(pulse), 32'h0);
    chk("R11 write cfg kept", cfg, c0);
  endtask

  task automatic t_ipi();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      wr(8'hA0 + 8'(i * 16), 32'h5500_0000 + 32'(i));
      chk("R10 ipi write index", 32'(last_ipi_sel), 32'(i));
      chk("R10 ipi write data", last_ipi_data, 32'h5500_0000 + 32'(i));
      rd(8'hA0 + 8'(i * 16), v);
      chk("R10 ipi read", v, 32'hC0DE_0000 + 32'(i));
    end
    chk("R10 ipi write count", 32'(ipi_wr_cnt), 32'd4);
    chk("R10 ipi read count", 32'(ipi_rd_cnt), 32'd4);
  endtask

  task automatic t_read_hold();
    logic [31:0] v;
    rd(8'h80, v); chk("R2 read value", v, VEND);
    repeat (3) @(negedge clk);
    chk("R2 hold", bus_rdata, VEND);
    wr(8'hF0, 32'h0000_1234);
    chk("R2 hold over write", bus_rdata, VEND);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    wr(8'hE0, 32'h0000_0042);
    wr(8'hF0, 32'h0000_7777);
    wr(8'h90, 32'h0000_0003);
    chk("R4 setup lines", 32'(proc_reset), 32'h3);
    wr(8'h20, 32'h8000_00F0);
    chk("R4 pulse high", 32'(pulse), 32'h1);
    chk("R4 spur reset", 32'(spur), 32'(SPR));
    chk("R4 tfrq reset", tfrq, TFR);
    chk("R4 lines low", 32'(proc_reset), 32'h0);
    chk("R3 cfg bit31 clear", cfg, 32'h0000_00F0);
    @(negedge clk);
    chk("R4 pulse one cycle", 32'(pulse), 32'h0);
    rd(8'h20, v); chk("R3 cfg read after cmd", v, 32'h0000_00F0);
    wr(8'h90, 32'h0000_0001);
    chk("R4 mask cleared, bit0 rises", 32'(proc_reset), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_ident();
    t_cfg();
    t_spur_tfrq();
    t_proc_reset();
    t_misaligned();
    t_unmapped();
    t_ipi();
    t_read_hold();
    t_soft_reset();
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule